// File: doc/BRIEF.md
# Single and Double Tap Detector

This block watches a stream of signed three-axis acceleration samples and reports taps. A tap is a short burst on any enabled axis: the magnitude climbs above a programmable threshold and drops back below it before a maximum duration has passed. After a first tap, the block can wait out a quiet latency period and then open a window for a second tap. A valid second tap yields a double-tap event. Durations come from a separate timebase tick input rather than from the clock, so the same logic serves any output data rate.

When double-tap reporting is active, the single-tap event is held back until the double-tap attempt has been settled one way or the other. A double tap is rejected if the signal is still high when the window opens, if the second tap runs too long, or (with suppression on) if any above-threshold sample shows up during latency. The block also keeps a per-axis record of which axes were above threshold on the sample that started the latest tap.

Top module: `tap_event_detector`

## Requirements
- R1: Each axis sample is a two's-complement value whose magnitude is compared against `thresh` shifted left by four bits. Only a magnitude strictly greater than that limit, on an enabled axis, counts as above threshold. A magnitude equal to the limit does not.
- R2: With double-tap reporting off, a tap that falls below threshold after fewer than `dur_lim` ticks produces a one-cycle `single_pulse`, which appears in the cycle after the falling sample.
- R3: A tap that stays above threshold for `dur_lim` ticks is discarded and produces no event.
- R4: With double-tap reporting on, a second tap that starts inside the window and falls within `dur_lim` ticks raises `double_pulse` and `single_pulse` in the same cycle.
- R5: The window opens after 2*`lat_lim` ticks of latency and closes after 2*`win_lim` further ticks. If no second tap begins, `single_pulse` fires when the window closes.
- R6: With `suppress` set, any above-threshold sample during latency cancels the double tap, and `single_pulse` fires at once.
- R7: With `suppress` clear, above-threshold samples during latency do not cancel the double tap, provided the last sample is below threshold when the window opens.
- R8: If the last sample is above threshold when the window opens, the double tap is cancelled and `single_pulse` fires.
- R9: A second tap lasting `dur_lim` ticks cancels the double tap, and `single_pulse` fires.
- R10: A `dur_lim` of zero disables all tap detection. A `lat_lim` or `win_lim` of zero disables double taps, so single taps are reported at their fall.
- R11: `src_axes` (bit 0 = X, bit 1 = Y, bit 2 = Z) takes the enabled above-threshold axes of the sample that starts each tap and holds them until the next tap starts. A disabled axis reads 0.
- R12: After reset both pulses and `src_axes` are 0, and each event pulse lasts one clock cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_valid | input | 1 | Sample strobe |
| smp_data | input | 48 | Signed samples {Z, Y, X}, 16 bits each |
| tick | input | 1 | Timebase tick, one unit per pulse |
| thresh | input | 8 | Unsigned tap threshold |
| dur_lim | input | 8 | Maximum tap duration in ticks |
| lat_lim | input | 8 | Latency in units of two ticks |
| win_lim | input | 8 | Second-tap window in units of two ticks |
| axis_en | input | 3 | Per-axis participation enable |
| suppress | input | 1 | Cancel double tap on activity during latency |
| single_en | input | 1 | Single-tap reporting enable |
| double_en | input | 1 | Double-tap reporting enable |
| single_pulse | output | 1 | Single-tap event pulse |
| double_pulse | output | 1 | Double-tap event pulse |
| src_axes | output | 3 | Axes above threshold at start of latest tap |

## Verification
The hardest case to reach is the window opening while the signal is still high. This needs a burst that begins inside latency, with suppression off, and is still in progress on the exact tick that ends latency. The stimulus counts latency ticks exactly: it injects a high sample partway through latency and delivers the remaining ticks before any low sample arrives. The same exact tick counting is used to place a second tap just after the window opens and to hold it high for exactly the duration limit.

// File: rtl/tapdet_pkg.sv
package tapdet_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_TAP1,
      ST_LAT,
      ST_WIN,
      ST_TAP2,
      ST_WAITLOW
   } tap_state_t;
endpackage

// File: rtl/tapdet_axis_cmp.sv
module tapdet_axis_cmp #(
   parameter int SAMPLE_W  = 16,
   parameter int AXES      = 3,
   parameter int THR_W     = 8,
   parameter int THR_SHIFT = 4
) (
   input  logic [AXES*SAMPLE_W-1:0] samples,
   input  logic [THR_W-1:0]         thresh,
   input  logic [AXES-1:0]          axis_en,
   output logic [AXES-1:0]          axis_hi
);
   localparam int LIMIT_W = THR_W + THR_SHIFT;

   if (LIMIT_W > SAMPLE_W) begin : g_bad_width
      $error("scaled threshold wider than sample");
   end

   logic [SAMPLE_W-1:0] limit;
   assign limit = SAMPLE_W'(thresh) << THR_SHIFT;

   for (genvar g = 0; g < AXES; g++) begin : g_axis
      logic [SAMPLE_W-1:0] raw;
      logic [SAMPLE_W-1:0] mag;
      assign raw = samples[g*SAMPLE_W +: SAMPLE_W];
      assign mag = raw[SAMPLE_W-1] ? (~raw + 1'b1) : raw;
      assign axis_hi[g] = axis_en[g] && (mag > limit);
   end
endmodule

// File: rtl/tapdet_timer.sv
module tapdet_timer #(
   parameter int CNT_W = 9
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             tick,
   output logic [CNT_W-1:0] cnt,
   output logic [CNT_W-1:0] cnt_inc
);
   assign cnt_inc = cnt + 1'b1;

   always_ff @(posedge clk) begin
      if (!rst_n || clr)
         cnt <= '0;
      else if (tick && cnt != '1)
         cnt <= cnt_inc;
   end
endmodule

// File: rtl/tapdet_fsm.sv
module tapdet_fsm
   import tapdet_pkg::*;
#(
   parameter int AXES   = 3,
   parameter int TIME_W = 8,
   localparam int CNT_W = TIME_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              smp_valid,
   input  logic [AXES-1:0]   axis_hi,
   input  logic              tick,
   input  logic [TIME_W-1:0] dur_lim,
   input  logic [TIME_W-1:0] lat_lim,
   input  logic [TIME_W-1:0] win_lim,
   input  logic [AXES-1:0]   axis_en,
   input  logic              suppress,
   input  logic              single_en,
   input  logic              double_en,
   input  logic [CNT_W-1:0]  cnt_inc,
   output logic              tmr_clr,
   output logic              single_q,
   output logic              double_q,
   output logic [AXES-1:0]   src_q
);
   tap_state_t state, nxt;
   logic above, fall, hi_q, cap, fire_s, fire_d, dbl_ok;
   logic [CNT_W-1:0] dur9, lat9, win9;

   assign above  = smp_valid && (|axis_hi);
   assign fall   = smp_valid && !(|axis_hi);
   assign dur9   = {1'b0, dur_lim};
   assign lat9   = {lat_lim, 1'b0};
   assign win9   = {win_lim, 1'b0};
   assign dbl_ok = double_en && (lat_lim != '0) && (win_lim != '0);

   always_comb begin
      nxt     = state;
      tmr_clr = 1'b0;
      fire_s  = 1'b0;
      fire_d  = 1'b0;
      cap     = 1'b0;
      unique case (state)
         ST_IDLE: begin
            tmr_clr = 1'b1;
            if (above && dur_lim != '0) begin
               nxt = ST_TAP1;
               cap = 1'b1;
            end
         end
         ST_TAP1: begin
            if (tick && cnt_inc >= dur9)
               nxt = ST_WAITLOW;
            else if (fall) begin
               tmr_clr = 1'b1;
               if (dbl_ok)
                  nxt = ST_LAT;
               else begin
                  nxt    = ST_IDLE;
                  fire_s = single_en;
               end
            end
         end
         ST_LAT: begin
            if (suppress && above) begin
               fire_s = single_en;
               nxt    = ST_WAITLOW;
            end else if (tick && cnt_inc >= lat9) begin
               tmr_clr = 1'b1;
               if (hi_q) begin
                  fire_s = single_en;
                  nxt    = ST_WAITLOW;
               end else
                  nxt = ST_WIN;
            end
         end
         ST_WIN: begin
            if (above) begin
               tmr_clr = 1'b1;
               cap     = 1'b1;
               nxt     = ST_TAP2;
            end else if (tick && cnt_inc >= win9) begin
               fire_s = single_en;
               nxt    = ST_IDLE;
            end
         end
         ST_TAP2: begin
            if (tick && cnt_inc >= dur9) begin
               fire_s = single_en;
               nxt    = ST_WAITLOW;
            end else if (fall) begin
               fire_s = single_en;
               fire_d = double_en;
               nxt    = ST_IDLE;
            end
         end
         ST_WAITLOW: begin
            if (fall) nxt = ST_IDLE;
         end
         default: nxt = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         hi_q     <= 1'b0;
         single_q <= 1'b0;
         double_q <= 1'b0;
         src_q    <= '0;
      end else begin
         state    <= nxt;
         single_q <= fire_s;
         double_q <= fire_d;
         if (smp_valid) hi_q <= |axis_hi;
         if (cap) src_q <= axis_hi;
      end
   end

   assert_dbl_with_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
      double_q |-> single_q);
   assert_dbl_after_tap2_R4: assert property (@(posedge clk) disable iff (!rst_n)
      double_q |-> ($past(state) == ST_TAP2));
   assert_pulse_width_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (single_q || double_q) |=> !(single_q || double_q));
   assert_src_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(state) != ST_IDLE && $past(state) != ST_WIN) |-> $stable(src_q));
   assert_src_masked_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(src_q) |-> ((src_q & ~$past(axis_en)) == '0));
   assert_zero_dur_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_IDLE && dur_lim == '0) |=> (state == ST_IDLE));
endmodule

// File: rtl/tap_event_detector.sv
module tap_event_detector #(
   parameter int SAMPLE_W  = 16,
   parameter int AXES      = 3,
   parameter int THR_W     = 8,
   parameter int THR_SHIFT = 4,
   parameter int TIME_W    = 8
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     smp_valid,
   input  logic [AXES*SAMPLE_W-1:0] smp_data,
   input  logic                     tick,
   input  logic [THR_W-1:0]         thresh,
   input  logic [TIME_W-1:0]        dur_lim,
   input  logic [TIME_W-1:0]        lat_lim,
   input  logic [TIME_W-1:0]        win_lim,
   input  logic [AXES-1:0]          axis_en,
   input  logic                     suppress,
   input  logic                     single_en,
   input  logic                     double_en,
   output logic                     single_pulse,
   output logic                     double_pulse,
   output logic [AXES-1:0]          src_axes
);
   localparam int CNT_W = TIME_W + 1;

   if (AXES < 1) begin : g_bad_axes
      $error("at least one axis required");
   end
   if (TIME_W < 1) begin : g_bad_time
      $error("time width must be positive");
   end

   logic [AXES-1:0]  axis_hi;
   logic [CNT_W-1:0] cnt, cnt_inc;
   logic             tmr_clr;

   tapdet_axis_cmp #(
      .SAMPLE_W (SAMPLE_W),
      .AXES     (AXES),
      .THR_W    (THR_W),
      .THR_SHIFT(THR_SHIFT)
   ) cmp_i (
      .samples(smp_data),
      .thresh (thresh),
      .axis_en(axis_en),
      .axis_hi(axis_hi)
   );

   tapdet_timer #(.CNT_W(CNT_W)) tmr_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (tmr_clr),
      .tick   (tick),
      .cnt    (cnt),
      .cnt_inc(cnt_inc)
   );

   tapdet_fsm #(.AXES(AXES), .TIME_W(TIME_W)) fsm_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .smp_valid(smp_valid),
      .axis_hi  (axis_hi),
      .tick     (tick),
      .dur_lim  (dur_lim),
      .lat_lim  (lat_lim),
      .win_lim  (win_lim),
      .axis_en  (axis_en),
      .suppress (suppress),
      .single_en(single_en),
      .double_en(double_en),
      .cnt_inc  (cnt_inc),
      .tmr_clr  (tmr_clr),
      .single_q (single_pulse),
      .double_q (double_pulse),
      .src_q    (src_axes)
   );

   logic unused_cnt;
   assign unused_cnt = ^cnt;
endmodule

// File: tb/tap_event_detector_tb_top.sv
module tap_event_detector_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        smp_valid = 1'b0;
   logic [47:0] smp_data = '0;
   logic        tick = 1'b0;
   logic [7:0]  thresh = 8'd4, dur_lim = 8'd10, lat_lim = 8'd5, win_lim = 8'd10;
   logic [2:0]  axis_en = 3'b111;
   logic        suppress = 1'b0, single_en = 1'b1, double_en = 1'b0;
   logic        single_pulse, double_pulse;
   logic [2:0]  src_axes;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   logic [4:0] exp_q[$];
   string      tag_q[$];

   always #10 clk = ~clk;

   tap_event_detector dut_i (
      .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
      .tick(tick), .thresh(thresh), .dur_lim(dur_lim), .lat_lim(lat_lim),
      .win_lim(win_lim), .axis_en(axis_en), .suppress(suppress),
      .single_en(single_en), .double_en(double_en),
      .single_pulse(single_pulse), .double_pulse(double_pulse), .src_axes(src_axes)
   );

   task automatic expect_ev(input bit dbl, input logic [2:0] src, input string tag);
      exp_q.push_back({dbl, 1'b1, src});
      tag_q.push_back(tag);
   endtask

   task automatic smp(input int x, input int y, input int z);
      @(negedge clk);
      smp_valid = 1'b1;
      smp_data  = {16'(z), 16'(y), 16'(x)};
      @(negedge clk);
      smp_valid = 1'b0;
   endtask

   task automatic ticks(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk); tick = 1'b1;
         @(negedge clk); tick = 1'b0;
      end
   endtask

   task automatic drain(input string tag);
      repeat (3) @(negedge clk);
      total++;
      if (exp_q.size() != 0) begin
         bad++;
         $display("FAIL %s: pending events actual=0 expected=%0d", tag, exp_q.size());
         exp_q.delete();
         tag_q.delete();
      end
   endtask

   task automatic chk_src(input logic [2:0] e, input string tag);
      total++;
      if (src_axes !== e) begin
         bad++;
         $display("FAIL %s: src_axes actual=%b expected=%b", tag, src_axes, e);
      end
   endtask

   // scoreboard monitor
   always @(negedge clk) begin
      if (rst_n && (single_pulse || double_pulse)) begin
         total++;
         if (exp_q.size() == 0) begin
            bad++;
            $display("FAIL unexpected event: actual=%b%b/%b expected=none",
                     double_pulse, single_pulse, src_axes);
         end else begin
            logic [4:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            if ({double_pulse, single_pulse, src_axes} !== e) begin
               bad++;
               $display("FAIL %s: event actual=%b expected=%b", t,
                        {double_pulse, single_pulse, src_axes}, e);
            end
         end
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R12 reset state
      total++;
      if (single_pulse !== 1'b0 || double_pulse !== 1'b0 || src_axes !== 3'b000) begin
         bad++;
         $display("FAIL R12: reset outputs actual=%b%b%b expected=000",
                  single_pulse, double_pulse, src_axes);
      end
      rst_n = 1'b1;
      @(negedge clk);

      // R2 single tap, double reporting off
      smp(100, 0, 0); ticks(3);
      expect_ev(1'b0, 3'b001, "R2");
      smp(0, 0, 0); drain("R2");
      chk_src(3'b001, "R11");

      // R3 overlong tap ignored
      smp(0, 100, 0); ticks(10); smp(0, 0, 0); drain("R3");
      chk_src(3'b010, "R11");

      // R1 equal magnitude not a tap, negative above is
      smp(64, -64, 64); smp(0, 0, 0); drain("R1");
      smp(-65, 0, 0); ticks(1);
      expect_ev(1'b0, 3'b001, "R1");
      smp(0, 0, 0); drain("R1");

      // R11 disabled axis
      axis_en = 3'b110;
      smp(500, 0, 0); smp(0, 0, 0); drain("R11");
      smp(500, 100, 0);
      expect_ev(1'b0, 3'b010, "R11");
      smp(0, 0, 0); drain("R11");
      chk_src(3'b010, "R11");
      axis_en = 3'b111;

      double_en = 1'b1;
      // R4 double tap
      smp(0, -200, 0); ticks(2); smp(0, 0, 0); ticks(12);
      expect_ev(1'b1, 3'b100, "R4");
      smp(0, 0, 300); ticks(2); smp(0, 0, 0); drain("R4");

      // R5 no second tap: single at window close
      smp(100, 0, 0); ticks(2); smp(0, 0, 0); ticks(10); ticks(19);
      drain("R5");
      expect_ev(1'b0, 3'b001, "R5");
      ticks(1); drain("R5");

      // R6 suppress during latency
      suppress = 1'b1;
      smp(100, 0, 0); ticks(2); smp(0, 0, 0); ticks(3);
      expect_ev(1'b0, 3'b001, "R6");
      smp(0, 100, 0); smp(0, 0, 0); drain("R6");
      suppress = 1'b0;

      // R7 activity in latency tolerated without suppress
      smp(100, 0, 0); ticks(2); smp(0, 0, 0); ticks(3);
      smp(0, 100, 0); smp(0, 0, 0); ticks(7);
      expect_ev(1'b1, 3'b100, "R7");
      smp(0, 0, 100); ticks(1); smp(0, 0, 0); drain("R7");

      // R8 high at window opening
      smp(100, 0, 0); ticks(2); smp(0, 0, 0); ticks(3);
      smp(0, 100, 0);
      expect_ev(1'b0, 3'b001, "R8");
      ticks(7); smp(0, 0, 0); drain("R8");

      // R9 overlong second tap
      smp(100, 0, 0); ticks(2); smp(0, 0, 0); ticks(10);
      smp(0, 100, 0);
      expect_ev(1'b0, 3'b010, "R9");
      ticks(10); smp(0, 0, 0); drain("R9");

      // R10 zero duration, then zero latency
      dur_lim = 8'd0;
      smp(0, 0, 100); ticks(2); smp(0, 0, 0); drain("R10");
      chk_src(3'b010, "R10");
      dur_lim = 8'd10; lat_lim = 8'd0;
      smp(100, 0, 0); ticks(2);
      expect_ev(1'b0, 3'b001, "R10");
      smp(0, 0, 0); drain("R10");

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule